// File: doc/BRIEF.md
# Scaled-Index Address Generator

This block forms a 32-bit memory target from up to three terms: a base register, an index register multiplied by a power of two, and a signed displacement. It sits after operand decode in a machine with eight general-purpose registers. The decoder gives it the whole register file, two register selects with enable flags, a 2-bit scale code, a displacement and a code for the displacement's size.

One request is accepted per clock. The address and an index-fault flag appear on registered outputs one cycle later. A valid pulse marks that cycle. Between requests the outputs keep their last values. Encoding 4 is the stack pointer, and it may not serve as an index. If it is requested as one, the block raises the fault and drops the index term from the sum.

Top module: `agu_ea`

## Requirements
- R1: With a request, the address is base + (index × 2^scale) + extended displacement. Register k is read from `gpr_i[32k+31:32k]`.
- R2: `scale_i` sets the index multiplier: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R3: `disp_sz_i` 00 takes `disp_i[7:0]` and sign-extends it. 01 takes `disp_i[15:0]` and sign-extends it. 10 and 11 take all 32 bits. Unused upper bits of `disp_i` have no effect.
- R4: A base with `base_en_i` low adds zero. An index with `idx_en_i` low adds zero and raises no fault.
- R5: `idx_en_i` high with `idx_sel_i` = 4 sets `fault_o` and adds zero for the index. In every other request `fault_o` is low, including when the base select is 4.
- R6: The sum wraps modulo 2^32 and no carry or overflow is reported.
- R7: `valid_o` is high in exactly the cycle after each cycle with `req_i` high. `ea_o` and `fault_o` change only after a request and hold otherwise.
- R8: After reset, `valid_o`, `fault_o` and `ea_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| req_i | input | 1 | compute request |
| gpr_i | input | 256 | register file, register k at bits 32k+31:32k |
| base_sel_i | input | 3 | base register number |
| base_en_i | input | 1 | base term present |
| idx_sel_i | input | 3 | index register number |
| idx_en_i | input | 1 | index term present |
| scale_i | input | 2 | index shift amount |
| disp_i | input | 32 | displacement |
| disp_sz_i | input | 2 | displacement size code |
| ea_o | output | 32 | effective address |
| valid_o | output | 1 | result valid, one cycle after request |
| fault_o | output | 1 | illegal index selection |

## Verification
The only state is the output register and the valid flag. A fault in either shows at the ports on the first clock after the request: a wrong sum, a lost or extra valid pulse, a fault that sticks, or outputs that drift while idle. The reference model predicts all three outputs every cycle, so each error appears at the next sample. Test vectors set the sign bit at each displacement width, place distinct patterns in all eight registers, and include wrapping sums. Without these, a mis-selected register or a wrong extension point could stay hidden.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
  typedef enum logic [1:0] {
    DSZ_8   = 2'b00,
    DSZ_16  = 2'b01,
    DSZ_32  = 2'b10,
    DSZ_32B = 2'b11
  } dsz_e;
endpackage

// File: rtl/agu_sext.sv
`timescale 1ns/1ps
module agu_sext
  import agu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] disp_i,
  input  dsz_e         sz_i,
  output logic [W-1:0] ext_o
);
  always_comb begin
    unique case (sz_i)
      DSZ_8:   ext_o = {{(W-8){disp_i[7]}}, disp_i[7:0]};
      DSZ_16:  ext_o = {{(W-16){disp_i[15]}}, disp_i[15:0]};
      default: ext_o = disp_i;
    endcase
  end
endmodule

// File: rtl/agu_pick.sv
`timescale 1ns/1ps
module agu_pick #(
  parameter int W        = 32,
  parameter int NREG     = 8,
  parameter int SPI      = 4,
  parameter bit CHECK_SP = 1'b0,
  localparam int AW      = $clog2(NREG)
) (
  input  logic [NREG*W-1:0] regs_i,
  input  logic [AW-1:0]     sel_i,
  input  logic              en_i,
  output logic [W-1:0]      val_o,
  output logic              bad_o
);
  localparam logic [AW-1:0] SP_SEL = AW'(SPI);

  logic [W-1:0] regs [NREG];
  for (genvar k = 0; k < NREG; k++) begin : g_unpack
    assign regs[k] = regs_i[k*W +: W];
  end

  if (CHECK_SP) begin : g_sp
    assign bad_o = en_i && (sel_i == SP_SEL);
  end else begin : g_nosp
    assign bad_o = 1'b0;
  end

  // blocked or absent operand contributes zero
  assign val_o = (en_i && !bad_o) ? regs[sel_i] : '0;
endmodule

// File: rtl/agu_ea.sv
`timescale 1ns/1ps
module agu_ea
  import agu_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 8,
  parameter int SPI  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [NREG*W-1:0] gpr_i,
  input  logic [AW-1:0]     base_sel_i,
  input  logic              base_en_i,
  input  logic [AW-1:0]     idx_sel_i,
  input  logic              idx_en_i,
  input  logic [1:0]        scale_i,
  input  logic [W-1:0]      disp_i,
  input  logic [1:0]        disp_sz_i,
  output logic [W-1:0]      ea_o,
  output logic              valid_o,
  output logic              fault_o
);
  localparam logic [AW-1:0] SP_SEL = AW'(SPI);

  logic [W-1:0] base_v, idx_v, idx_sc, disp_x, ea_d;
  logic         base_bad, idx_bad;

  agu_pick #(.W(W), .NREG(NREG), .SPI(SPI), .CHECK_SP(1'b0)) i_base (
    .regs_i(gpr_i), .sel_i(base_sel_i), .en_i(base_en_i),
    .val_o(base_v), .bad_o(base_bad)
  );

  agu_pick #(.W(W), .NREG(NREG), .SPI(SPI), .CHECK_SP(1'b1)) i_idx (
    .regs_i(gpr_i), .sel_i(idx_sel_i), .en_i(idx_en_i),
    .val_o(idx_v), .bad_o(idx_bad)
  );

  agu_sext #(.W(W)) i_sext (
    .disp_i(disp_i), .sz_i(dsz_e'(disp_sz_i)), .ext_o(disp_x)
  );

  assign idx_sc = idx_v << scale_i;
  assign ea_d   = base_v + idx_sc + disp_x;  // wraps mod 2^W

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_o    <= '0;
      fault_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        ea_o    <= ea_d;
        fault_o <= idx_bad | base_bad;
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o); // R7
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(ea_o) && $stable(fault_o))); // R7
  AST_SP_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && idx_en_i && idx_sel_i == SP_SEL) |=> fault_o); // R5
  AST_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(idx_en_i && idx_sel_i == SP_SEL)) |=> !fault_o); // R5
endmodule

// File: tb/test_agu_ea.sv
`timescale 1ns/1ps
module test_agu_ea;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] regs [8];
  logic [255:0] gpr;
  logic [2:0]  bsel = '0, isel = '0;
  logic        ben = 1'b0, ien = 1'b0;
  logic [1:0]  sc = '0, dsz = '0;
  logic [31:0] disp = '0;
  logic [31:0] ea;
  logic        valid, fault;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_ea = '0;
  logic        exp_fault = 1'b0;

  always #2.5 clk = ~clk;

  always_comb
    for (int k = 0; k < 8; k++) gpr[k*32 +: 32] = regs[k];

  agu_ea i_agu_ea (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gpr_i(gpr),
    .base_sel_i(bsel), .base_en_i(ben), .idx_sel_i(isel), .idx_en_i(ien),
    .scale_i(sc), .disp_i(disp), .disp_sz_i(dsz),
    .ea_o(ea), .valid_o(valid), .fault_o(fault)
  );

  function automatic logic [31:0] model_ea();
    longint unsigned s = 0;
    longint signed   d;
    case (dsz)
      2'b00:   d = longint'($signed(disp[7:0]));
      2'b01:   d = longint'($signed(disp[15:0]));
      default: d = longint'(disp);
    endcase
    if (ben) s += regs[bsel];
    if (ien && isel != 3'd4) s += longint'(regs[isel]) * (longint'(1) << sc);
    s += longint'(d);
    return s[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] e_ea, logic e_v, logic e_f);
    n_chk++;
    if (ea !== e_ea || valid !== e_v || fault !== e_f) begin
      n_bad++;
      $display("FAIL %s: ea=%h valid=%b fault=%b expected ea=%h valid=%b fault=%b",
               tag, ea, valid, fault, e_ea, e_v, e_f);
    end
  endtask

  // drive one cycle, then compare at the following falling edge
  task automatic step(string tag, logic r);
    req = r;
    if (r) begin
      exp_ea    = model_ea();
      exp_fault = ien && isel == 3'd4;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, exp_ea, r, exp_fault);
  endtask

  task automatic set_op(logic be, logic [2:0] bs, logic ie, logic [2:0] is,
                        logic [1:0] s, logic [31:0] d, logic [1:0] z);
    ben = be; bsel = bs; ien = ie; isel = is; sc = s; disp = d; dsz = z;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: ran out of time, expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) regs[k] = 32'h0101_0000 * (k + 1) + 32'h10 * k;
    repeat (3) @(negedge clk);
    check("R8 reset", 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    step("R8 idle after reset", 1'b0);

    set_op(1, 3'd1, 1, 3'd2, 2'b00, 32'h0000_0004, 2'b10); step("R1 sum", 1'b1);
    for (int s = 0; s < 4; s++) begin
      set_op(1, 3'd0, 1, 3'd3, 2'(s), 32'h0, 2'b10); step("R2 scale", 1'b1);
    end
    set_op(1, 3'd5, 0, 3'd0, 2'b00, 32'hABCD_EF80, 2'b00); step("R3 disp8 negative", 1'b1);
    set_op(1, 3'd5, 0, 3'd0, 2'b00, 32'hFFFF_FF7F, 2'b00); step("R3 disp8 positive", 1'b1);
    set_op(1, 3'd6, 0, 3'd0, 2'b00, 32'h1234_8001, 2'b01); step("R3 disp16 negative", 1'b1);
    set_op(1, 3'd6, 0, 3'd0, 2'b00, 32'hFFFF_7FFF, 2'b01); step("R3 disp16 positive", 1'b1);
    set_op(1, 3'd6, 0, 3'd0, 2'b00, 32'h8000_0001, 2'b11); step("R3 disp32 code 11", 1'b1);
    set_op(0, 3'd7, 1, 3'd7, 2'b01, 32'h20, 2'b10); step("R4 no base", 1'b1);
    set_op(1, 3'd7, 0, 3'd4, 2'b11, 32'h20, 2'b10); step("R4 no index, sp select ignored", 1'b1);
    set_op(0, 3'd0, 0, 3'd0, 2'b00, 32'h0, 2'b10); step("R4 nothing", 1'b1);
    set_op(1, 3'd2, 1, 3'd4, 2'b10, 32'h8, 2'b00); step("R5 sp index fault", 1'b1);
    set_op(1, 3'd4, 1, 3'd1, 2'b01, 32'h8, 2'b00); step("R5 sp base legal", 1'b1);
    regs[0] = 32'hFFFF_FFF0;
    set_op(1, 3'd0, 0, 3'd0, 2'b00, 32'h20, 2'b10); step("R6 wrap", 1'b1);
    regs[1] = 32'h8000_0000;
    set_op(1, 3'd0, 1, 3'd1, 2'b11, 32'hFFFF_FFFF, 2'b10); step("R6 wrap scaled", 1'b1);
    set_op(1, 3'd2, 1, 3'd4, 2'b10, 32'h8, 2'b00); step("R7 fault set", 1'b1);
    set_op(1, 3'd3, 1, 3'd5, 2'b01, 32'h44, 2'b10);
    step("R7 hold 1", 1'b0);
    step("R7 hold 2", 1'b0);
    step("R7 after hold", 1'b1);

    for (int i = 0; i < 300; i++) begin
      for (int k = 0; k < 8; k++) regs[k] = $urandom;
      set_op(1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom),
             2'($urandom), $urandom, 2'($urandom));
      step("R1 R7 random", 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule